// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Selector

This cell picks one of two free-running clocks and drives it onto a single output clock. Changing the choice never produces a runt pulse or a cut-short phase. The cell lets the outgoing clock finish its high phase and then holds the output low. It releases the incoming clock only after that clock has itself seen a falling edge, so the first phase passed on from the new source is a full high phase. Downstream logic keeps running through a switch and needs no reset.

Each source has its own select line and its own enable line. A source is a candidate only when both of its lines are high. If both sources are candidates, source A wins. Dropping every enable holds the output quiet, which gates the whole clock tree behind it.

A handshake crosses between the two clock domains. Each side has a short chain of flops clocked on the falling edge of its own clock, and a side may start only once the other side's chain is empty. A per-source bypass input lets the switch abandon a source without waiting for that source's edges. This is how the output moves away from a clock that has stopped.

Top module: `glitchFreeClkMux`

## Requirements
- R1: While `rstN` is low, `clkOut` stays low and neither source is passed, whatever the select and enable inputs are.
- R2: A source counts as requested only when both its select input and its enable input are 1. A select at 1 with its enable at 0 does not pass that source.
- R3: When only source A is requested, then after at most three falling edges of each clock, `clkOut` equals `clkA`: high in every high phase of `clkA` and low in every low phase.
- R4: When only source B is requested, then after the same settling time, `clkOut` equals `clkB`.
- R5: When both sources are requested, source A is passed and source B is kept off.
- R6: When no source is requested, `clkOut` is held low and shows no rising edge.
- R7: No high or low phase of `clkOut` is shorter than the shorter half-period of the two input clocks. The two sources are never passed at the same time. A source's pass state changes only while that source's clock is low, unless its bypass is asserted.
- R8: When the bypass input of a source that is no longer requested is 1, that source is released at once, without any edge of its clock. If that input is 0 and the source's clock has stopped, the switch stays pending and `clkOut` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low reset of the handshake flops |
| clkA | input | 1 | Source clock A |
| clkB | input | 1 | Source clock B |
| selA | input | 1 | Select line for source A |
| selB | input | 1 | Select line for source B |
| enA | input | 1 | Enable for source A |
| enB | input | 1 | Enable for source B |
| ignA | input | 1 | Bypass: release A without waiting for its edges |
| ignB | input | 1 | Bypass: release B without waiting for its edges |
| clkOut | output | 1 | Selected, glitch-free output clock |

## Verification
The bench runs all sixteen combinations of the four select and enable inputs in sequence. This exercises every kind of switch: A to B, B to A, either source to silence, and back again. It compares the output's rising edges and levels with the source that the combination predicts. A selector that made before it broke, or that changed its pass state in a high phase, would leave a phase shorter than 4 ns, and the pulse-width monitor running over the whole run catches that. A selector that ignored the enable would keep passing a source whose enable is low. A selector with the wrong priority would pass B when both sources are requested. The bench also stops each clock in turn: a bypass that is not wired in would leave the output dead, and a selector that skipped the handshake would move to the new source even with the bypass low.

// File: rtl/clkMuxPkg.sv
`timescale 1ns/1ps
package clkMuxPkg;
  localparam int NUM_SRC = 2;
  localparam int SRC_A   = 0;
  localparam int SRC_B   = 1;

  // Pass strobes handed from the handshake control to the gating datapath
  typedef struct packed {
    logic gateB;
    logic gateA;
  } muxGates_t;
endpackage

// File: rtl/clkMuxSideSync.sv
`timescale 1ns/1ps
module clkMuxSideSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic release_,
  input  logic d,
  output logic busy,
  output logic grant
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] stg;
  logic clr;

  // reset or bypass-release empties the chain without a clock edge
  assign clr = ~rstN | release_;

  always_ff @(negedge clk or posedge clr) begin
    if (clr) stg <= '0;
    else     stg <= {stg[LAST-1:0], d};
  end

  assign grant = stg[LAST];
  assign busy  = |stg;
endmodule

// File: rtl/clkMuxCtrl.sv
`timescale 1ns/1ps
module clkMuxCtrl
  import clkMuxPkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      rstN,
  input  logic      clkA,
  input  logic      clkB,
  input  logic      selA,
  input  logic      selB,
  input  logic      enA,
  input  logic      enB,
  input  logic      ignA,
  input  logic      ignB,
  output muxGates_t gates
);
  logic [NUM_SRC-1:0] clkVec, reqVec, ignVec, busyVec, grantVec;

  assign clkVec = {clkB, clkA};
  assign ignVec = {ignB, ignA};

  // a source is requested only with both select and enable; A has priority
  assign reqVec[SRC_A] = selA & enA;
  assign reqVec[SRC_B] = selB & enB & ~reqVec[SRC_A];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_side
    localparam int OTHER = NUM_SRC - 1 - i;
    logic dIn, relIn;

    assign dIn   = reqVec[i] & ~busyVec[OTHER];
    assign relIn = ignVec[i] & ~reqVec[i];

    clkMuxSideSync #(.STAGES(STAGES)) u_sync (
      .clk     (clkVec[i]),
      .rstN    (rstN),
      .release_(relIn),
      .d       (dIn),
      .busy    (busyVec[i]),
      .grant   (grantVec[i])
    );
  end

  assign gates.gateA = grantVec[SRC_A];
  assign gates.gateB = grantVec[SRC_B];
endmodule

// File: rtl/clkMuxGate.sv
`timescale 1ns/1ps
module clkMuxGate
  import clkMuxPkg::*;
(
  input  logic      clkA,
  input  logic      clkB,
  input  muxGates_t gates,
  output logic      clkOut
);
  // strobes only change while their clock is low, so the AND-OR stays clean
  assign clkOut = (clkA & gates.gateA) | (clkB & gates.gateB);
endmodule

// File: rtl/glitchFreeClkMux.sv
`timescale 1ns/1ps
module glitchFreeClkMux
  import clkMuxPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic rstN,
  input  logic clkA,
  input  logic clkB,
  input  logic selA,
  input  logic selB,
  input  logic enA,
  input  logic enB,
  input  logic ignA,
  input  logic ignB,
  output logic clkOut
);
  muxGates_t gates;

  clkMuxCtrl #(.STAGES(SYNC_STAGES)) u_ctrl (
    .rstN (rstN),
    .clkA (clkA),
    .clkB (clkB),
    .selA (selA),
    .selB (selB),
    .enA  (enA),
    .enB  (enB),
    .ignA (ignA),
    .ignB (ignB),
    .gates(gates)
  );

  clkMuxGate u_gate (
    .clkA  (clkA),
    .clkB  (clkB),
    .gates (gates),
    .clkOut(clkOut)
  );
endmodule

// File: rtl/glitchFreeClkMuxChk.sv
`timescale 1ns/1ps
module glitchFreeClkMuxChk (
  input logic rstN,
  input logic clkA,
  input logic clkB,
  input logic ignA,
  input logic ignB,
  input logic gateA,
  input logic gateB,
  input logic clkOut
);
  // R7
  excl_grant_chk: assert property (@(posedge clkA) disable iff (!rstN)
    !(gateA && gateB));

  // R7
  always @(gateA) begin
    if (rstN && !ignA) begin
      gate_a_low_chk: assert (!clkA);
    end
  end

  // R7
  always @(gateB) begin
    if (rstN && !ignB) begin
      gate_b_low_chk: assert (!clkB);
    end
  end

  // R3
  follow_a_chk: assert property (@(negedge clkA) disable iff (!rstN)
    gateA |-> clkOut);

  // R4
  follow_b_chk: assert property (@(negedge clkB) disable iff (!rstN)
    gateB |-> clkOut);
endmodule

bind glitchFreeClkMux glitchFreeClkMuxChk u_chk (
  .rstN  (rstN),
  .clkA  (clkA),
  .clkB  (clkB),
  .ignA  (ignA),
  .ignB  (ignB),
  .gateA (gates.gateA),
  .gateB (gates.gateB),
  .clkOut(clkOut)
);

// File: tb/sim_glitchFreeClkMux.sv
`timescale 1ns/1ps
module sim_glitchFreeClkMux;
  localparam real HALF_A = 4.0;   // 125 MHz
  localparam real HALF_B = 7.0;

  logic rstN = 1'b0;
  logic clkA = 1'b0, clkB = 1'b0;
  logic selA = 1'b0, selB = 1'b0, enA = 1'b0, enB = 1'b0;
  logic ignA = 1'b0, ignB = 1'b0;
  logic clkOut;
  bit runA = 1'b1, runB = 1'b1;

  int checks = 0, errors = 0;
  int outRises = 0, aRises = 0, bRises = 0;
  real lastEdge = -1.0, minPhase = 1.0e9;

  glitchFreeClkMux u0 (
    .rstN(rstN), .clkA(clkA), .clkB(clkB), .selA(selA), .selB(selB),
    .enA(enA), .enB(enB), .ignA(ignA), .ignB(ignB), .clkOut(clkOut)
  );

  always begin #(HALF_A); if (runA) clkA = ~clkA; end
  always begin #(HALF_B); if (runB) clkB = ~clkB; end

  always @(posedge clkOut) outRises++;
  always @(posedge clkA) aRises++;
  always @(posedge clkB) bRises++;

  // phase-width monitor for R7
  always @(clkOut) begin
    if (rstN) begin
      if (lastEdge >= 0.0 && ($realtime - lastEdge) < minPhase)
        minPhase = $realtime - lastEdge;
      lastEdge = $realtime;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // src: 0 none, 1 A, 2 B; counts output edges over a window
  task automatic risesChk(input int src, input string tag);
    int o0 = outRises, a0 = aRises, b0 = bRises, exp;
    #100;
    exp = (src == 1) ? aRises - a0 : (src == 2) ? bRises - b0 : 0;
    check((outRises - o0) == exp, tag, outRises - o0, exp);
  endtask

  // level comparison one ns into each phase of the chosen source
  task automatic followChk(input int src, input string tag);
    int bad = 0;
    for (int k = 0; k < 5; k++) begin
      if (src == 1) begin
        @(posedge clkA); #1; if (clkOut !== 1'b1) bad++;
        @(negedge clkA); #1; if (clkOut !== 1'b0) bad++;
      end else begin
        @(posedge clkB); #1; if (clkOut !== 1'b1) bad++;
        @(negedge clkB); #1; if (clkOut !== 1'b0) bad++;
      end
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: requests present during reset must not pass
    selA = 1; enA = 1; selB = 1; enB = 1;
    #5;
    risesChk(0, "R1 rises in reset");
    check(clkOut === 1'b0, "R1 level in reset", int'(clkOut), 0);
    selB = 0; enB = 0;
    @(negedge clkA); rstN = 1;

    #100; followChk(1, "R3 follow A"); risesChk(1, "R3 rises A");

    // sweep every select/enable combination
    for (int c = 0; c < 16; c++) begin
      int src;
      bit rA, rB;
      selA = c[0]; enA = c[1]; selB = c[2]; enB = c[3];
      rA = c[0] & c[1];
      rB = c[2] & c[3] & ~rA;
      src = rA ? 1 : rB ? 2 : 0;
      #100;
      if (src == 1) begin
        followChk(1, (c[2] & c[3]) ? "R5 both requested" : "R3 sweep A");
        risesChk(1, "R2 sweep rises A");
      end else if (src == 2) begin
        followChk(2, "R4 sweep B");
        risesChk(2, c[0] ? "R2 select without enable" : "R4 sweep rises B");
      end else begin
        risesChk(0, "R6 silent output");
        check(clkOut === 1'b0, "R6 silent level", int'(clkOut), 0);
      end
    end

    // R8: A stops low while passed, switch to B
    selA = 1; enA = 1; selB = 0; enB = 0; #100;
    @(negedge clkA); runA = 0;
    selA = 0; selB = 1; enB = 1;
    #150; risesChk(0, "R8 stuck without bypass");
    ignA = 1; #100;
    followChk(2, "R8 bypass releases A"); risesChk(2, "R8 rises B");
    ignA = 0; runA = 1; #50;

    // R8: B stops low while passed, switch to A
    @(negedge clkB); runB = 0;
    selB = 0; selA = 1;
    #150; risesChk(0, "R8 stuck without bypass B");
    ignB = 1; #100;
    followChk(1, "R8 bypass releases B"); risesChk(1, "R8 rises A");
    ignB = 0; runB = 1; #100;

    check(minPhase >= HALF_A - 0.001, "R7 shortest phase ps",
          int'(minPhase * 1000.0), int'(HALF_A * 1000.0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule